// File: doc/BRIEF.md
# Single-Bus Multicycle Control Sequencer

This block is the control unit of a processor built around one shared 32-bit bus. Each clock cycle it sits in exactly one state and raises the enables for that step. These enables cover which unit drives the bus, which registers capture the bus, and whether the register file or memory is written. It also produces a register-file port choice and a 2-bit ALU operation. The state sequence covers instruction fetch, the memory-reference instructions (load and store), and set-on-less-than. All other opcodes fall straight back to fetch.

Fetch takes three cycles. The PC value goes onto the bus once and is captured by both the A operand register and the memory address register. Set-on-less-than has no comparator. It subtracts, latches the sign of the difference into a 1-bit N register, and then forms the result as either zero plus one or zero plus zero, reading the hard-wired zero register. The inputs are the opcode field of the instruction register and the latched N bit. Every control output is plain and level-sensitive, with no handshake: the datapath acts on whatever is asserted in a cycle. The sequencer has no flow-control inputs, so it never stalls.

Top module: `bus_ctl_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes fetch step 1. While `rst` is high, every output is 0. In the first cycle after `rst` falls, the outputs are those of fetch step 1.
- R2: Fetch is three cycles, using ALU code 11 = A+1. Step 1 raises drv_pc, ld_a and ld_mar. Step 2 raises drv_mem and ld_ir. Step 3 raises drv_alu and ld_pc with alu_fn=11.
- R3: The opcode is decoded in fetch step 3. Opcodes 4'h4 (load) and 4'h5 (store) go to address step 1. Opcode 4'h9 (set-on-less-than) goes to compare step 1. Any other opcode returns to fetch step 1.
- R4: Address calculation has three steps. Step 1 raises drv_reg and ld_a with reg_sel=00 (RA). Step 2 raises drv_off and ld_b. Step 3 raises drv_alu and ld_mar with alu_fn=00 (add). Step 3 then goes to the load or store final state, chosen by the opcode.
- R5: The load final state raises drv_mem and wr_reg with reg_sel=01 (RB). The next state is fetch step 1.
- R6: The store final state raises drv_reg and wr_mem with reg_sel=01. The next state is fetch step 1.
- R7: Compare step 1 raises drv_reg and ld_a with reg_sel=00. Step 2 raises drv_reg and ld_b with reg_sel=01. Step 3 sets alu_fn=10 (A-B) and raises ld_n, with no bus driver enabled.
- R8: Compare step 4 raises drv_reg, ld_a and ld_b with reg_sel=11 (zero register). Step 4 goes to the result-one state if n_flag is 1 in that cycle, and to the result-zero state otherwise.
- R9: Result-one uses alu_fn=11 and result-zero uses alu_fn=00. Both raise drv_alu and wr_reg with reg_sel=10 (RD), and both go next to fetch step 1.
- R10: At most one of drv_pc, drv_alu, drv_reg, drv_mem and drv_off is high in any cycle. ld_z is never raised. Outside the states listed above, reg_sel and alu_fn are 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Opcode field of the instruction register |
| n_flag | input | 1 | Latched ALU sign bit |
| drv_pc | output | 1 | PC drives the bus |
| drv_alu | output | 1 | ALU result drives the bus |
| drv_reg | output | 1 | Selected register drives the bus |
| drv_mem | output | 1 | Memory read data drives the bus |
| drv_off | output | 1 | Sign-extended offset drives the bus |
| ld_pc | output | 1 | PC captures the bus |
| ld_a | output | 1 | A operand captures the bus |
| ld_b | output | 1 | B operand captures the bus |
| ld_mar | output | 1 | Memory address register captures the bus |
| ld_ir | output | 1 | Instruction register captures the bus |
| ld_n | output | 1 | N captures the ALU sign bit |
| ld_z | output | 1 | Z capture enable (never raised) |
| wr_reg | output | 1 | Register file write |
| wr_mem | output | 1 | Memory write |
| reg_sel | output | 2 | Register port choice: 00 RA, 01 RB, 10 RD, 11 zero |
| alu_fn | output | 2 | ALU op: 00 add, 10 A-B, 11 A+1 |

## Verification
The hardest paths to reach from the ports are the two arms of the N branch and a reset that arrives partway through an instruction. The bench reaches the N branch by running set-on-less-than twice, once with n_flag held high and once held low, so compare step 4 sees each value. It reaches the mid-instruction reset by truncating a load after its address step and a compare before its result state, then pulsing reset. It then checks that the next cycle is a clean fetch step 1 and that a full instruction follows.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int OPW = 4;

  localparam logic [OPW-1:0] OPC_LOAD  = 4'h4;
  localparam logic [OPW-1:0] OPC_STORE = 4'h5;
  localparam logic [OPW-1:0] OPC_SLT   = 4'h9;

  typedef enum logic [3:0] {
    ST_FE1, ST_FE2, ST_FE3,
    ST_AC1, ST_AC2, ST_AC3,
    ST_LDW, ST_STW,
    ST_CP1, ST_CP2, ST_CP3, ST_CP4,
    ST_SET1, ST_SET0
  } seq_state_e;

  typedef enum logic [1:0] {
    SEL_RA = 2'b00,
    SEL_RB = 2'b01,
    SEL_RD = 2'b10,
    SEL_R0 = 2'b11
  } rsel_e;

  typedef enum logic [1:0] {
    FN_ADD = 2'b00,
    FN_RSV = 2'b01,
    FN_SUB = 2'b10,
    FN_INC = 2'b11
  } alufn_e;

  typedef struct packed {
    logic   drv_pc;
    logic   drv_alu;
    logic   drv_reg;
    logic   drv_mem;
    logic   drv_off;
    logic   ld_pc;
    logic   ld_a;
    logic   ld_b;
    logic   ld_mar;
    logic   ld_ir;
    logic   ld_n;
    logic   ld_z;
    logic   wr_reg;
    logic   wr_mem;
    rsel_e  sel;
    alufn_e fn;
  } ctl_t;

endpackage

// File: rtl/seq_next.sv
module seq_next
  import seq_pkg::*;
(
  input  seq_state_e     cur,
  input  logic [OPW-1:0] opcode,
  input  logic           n_flag,
  output seq_state_e     nxt
);

  always_comb begin
    nxt = ST_FE1;
    unique case (cur)
      ST_FE1: nxt = ST_FE2;
      ST_FE2: nxt = ST_FE3;
      ST_FE3: begin
        if (opcode == OPC_LOAD || opcode == OPC_STORE) nxt = ST_AC1;
        else if (opcode == OPC_SLT)                    nxt = ST_CP1;
        else                                           nxt = ST_FE1;
      end
      ST_AC1: nxt = ST_AC2;
      ST_AC2: nxt = ST_AC3;
      ST_AC3: nxt = (opcode == OPC_STORE) ? ST_STW : ST_LDW;
      ST_LDW: nxt = ST_FE1;
      ST_STW: nxt = ST_FE1;
      ST_CP1: nxt = ST_CP2;
      ST_CP2: nxt = ST_CP3;
      ST_CP3: nxt = ST_CP4;
      ST_CP4: nxt = n_flag ? ST_SET1 : ST_SET0;
      ST_SET1: nxt = ST_FE1;
      ST_SET0: nxt = ST_FE1;
      default: nxt = ST_FE1;
    endcase
  end

endmodule

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  seq_state_e cur,
  output ctl_t       ctl
);

  always_comb begin
    ctl     = '0;
    ctl.sel = SEL_RA;
    ctl.fn  = FN_ADD;
    unique case (cur)
      ST_FE1: begin ctl.drv_pc = 1'b1; ctl.ld_a = 1'b1; ctl.ld_mar = 1'b1; end
      ST_FE2: begin ctl.drv_mem = 1'b1; ctl.ld_ir = 1'b1; end
      ST_FE3: begin ctl.fn = FN_INC; ctl.drv_alu = 1'b1; ctl.ld_pc = 1'b1; end
      ST_AC1: begin ctl.sel = SEL_RA; ctl.drv_reg = 1'b1; ctl.ld_a = 1'b1; end
      ST_AC2: begin ctl.drv_off = 1'b1; ctl.ld_b = 1'b1; end
      ST_AC3: begin ctl.fn = FN_ADD; ctl.drv_alu = 1'b1; ctl.ld_mar = 1'b1; end
      ST_LDW: begin ctl.sel = SEL_RB; ctl.drv_mem = 1'b1; ctl.wr_reg = 1'b1; end
      ST_STW: begin ctl.sel = SEL_RB; ctl.drv_reg = 1'b1; ctl.wr_mem = 1'b1; end
      ST_CP1: begin ctl.sel = SEL_RA; ctl.drv_reg = 1'b1; ctl.ld_a = 1'b1; end
      ST_CP2: begin ctl.sel = SEL_RB; ctl.drv_reg = 1'b1; ctl.ld_b = 1'b1; end
      ST_CP3: begin ctl.fn = FN_SUB; ctl.ld_n = 1'b1; end
      ST_CP4: begin
        ctl.sel = SEL_R0; ctl.drv_reg = 1'b1; ctl.ld_a = 1'b1; ctl.ld_b = 1'b1;
      end
      ST_SET1: begin
        ctl.fn = FN_INC; ctl.sel = SEL_RD; ctl.drv_alu = 1'b1; ctl.wr_reg = 1'b1;
      end
      ST_SET0: begin
        ctl.fn = FN_ADD; ctl.sel = SEL_RD; ctl.drv_alu = 1'b1; ctl.wr_reg = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/bus_ctl_seq.sv
module bus_ctl_seq
  import seq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  input  logic           n_flag,
  output logic           drv_pc,
  output logic           drv_alu,
  output logic           drv_reg,
  output logic           drv_mem,
  output logic           drv_off,
  output logic           ld_pc,
  output logic           ld_a,
  output logic           ld_b,
  output logic           ld_mar,
  output logic           ld_ir,
  output logic           ld_n,
  output logic           ld_z,
  output logic           wr_reg,
  output logic           wr_mem,
  output logic [1:0]     reg_sel,
  output logic [1:0]     alu_fn
);

  seq_state_e state_q, state_d;
  ctl_t       ctl_raw, ctl_out;

  seq_next u_next (
    .cur    (state_q),
    .opcode (opcode),
    .n_flag (n_flag),
    .nxt    (state_d)
  );

  seq_decode u_dec (
    .cur (state_q),
    .ctl (ctl_raw)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FE1;
    else     state_q <= state_d;
  end

  always_comb begin
    if (rst) ctl_out = '0;
    else     ctl_out = ctl_raw;
  end

  assign drv_pc  = ctl_out.drv_pc;
  assign drv_alu = ctl_out.drv_alu;
  assign drv_reg = ctl_out.drv_reg;
  assign drv_mem = ctl_out.drv_mem;
  assign drv_off = ctl_out.drv_off;
  assign ld_pc   = ctl_out.ld_pc;
  assign ld_a    = ctl_out.ld_a;
  assign ld_b    = ctl_out.ld_b;
  assign ld_mar  = ctl_out.ld_mar;
  assign ld_ir   = ctl_out.ld_ir;
  assign ld_n    = ctl_out.ld_n;
  assign ld_z    = ctl_out.ld_z;
  assign wr_reg  = ctl_out.wr_reg;
  assign wr_mem  = ctl_out.wr_mem;
  assign reg_sel = ctl_out.sel;
  assign alu_fn  = ctl_out.fn;

endmodule

// File: rtl/bus_ctl_seq_chk.sv
module bus_ctl_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] opcode,
  input logic       n_flag,
  input logic       drv_pc,
  input logic       drv_alu,
  input logic       drv_reg,
  input logic       drv_mem,
  input logic       drv_off,
  input logic       ld_pc,
  input logic       ld_a,
  input logic       ld_b,
  input logic       ld_mar,
  input logic       ld_ir,
  input logic       ld_n,
  input logic       ld_z,
  input logic       wr_reg,
  input logic       wr_mem,
  input logic [1:0] reg_sel,
  input logic [1:0] alu_fn
);

  logic [4:0] drivers;
  assign drivers = {drv_pc, drv_alu, drv_reg, drv_mem, drv_off};

  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    rst |-> (drivers == 5'd0 && !ld_a && !ld_mar && !wr_reg && !wr_mem));

  assert_fetch_two_R2: assert property (@(posedge clk) disable iff (rst)
    (drv_pc && ld_mar) |=> (drv_mem && ld_ir));

  assert_fetch_three_R2: assert property (@(posedge clk) disable iff (rst)
    (drv_mem && ld_ir) |=> (drv_alu && ld_pc && alu_fn == 2'b11));

  assert_mem_ref_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (drv_alu && ld_pc && (opcode == 4'h4 || opcode == 4'h5))
      |=> (drv_reg && ld_a && reg_sel == 2'b00));

  assert_back_to_fetch_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_reg || wr_mem) |=> (drv_pc && ld_a && ld_mar));

  assert_sign_latch_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    ld_n |-> (drivers == 5'd0 && alu_fn == 2'b10));

  assert_branch_one_R8: assert property (@(posedge clk) disable iff (rst)
    (ld_a && ld_b && reg_sel == 2'b11 && n_flag) |=> (wr_reg && alu_fn == 2'b11));

  assert_branch_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (ld_a && ld_b && reg_sel == 2'b11 && !n_flag) |=> (wr_reg && alu_fn == 2'b00));

  assert_single_driver_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drivers) && !ld_z);

endmodule

bind bus_ctl_seq bus_ctl_seq_chk u_chk (.*);

// File: tb/test_bus_ctl_seq.sv
module test_bus_ctl_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opcode = 4'h0;
  logic       n_flag = 1'b0;
  logic drv_pc, drv_alu, drv_reg, drv_mem, drv_off;
  logic ld_pc, ld_a, ld_b, ld_mar, ld_ir, ld_n, ld_z, wr_reg, wr_mem;
  logic [1:0] reg_sel, alu_fn;

  int runs = 0;
  int fails = 0;
  int budget = 0;
  int pushed = 0;
  bit done = 1'b0;

  logic [17:0] q_vec[$];
  string       q_tag[$];

  localparam logic [13:0] B_DPC = 14'h2000, B_DALU = 14'h1000, B_DREG = 14'h0800,
                          B_DMEM = 14'h0400, B_DOFF = 14'h0200, B_LPC = 14'h0100,
                          B_LA = 14'h0080, B_LB = 14'h0040, B_LMAR = 14'h0020,
                          B_LIR = 14'h0010, B_LN = 14'h0008, B_LZ = 14'h0004,
                          B_WREG = 14'h0002, B_WMEM = 14'h0001;

  always #2 clk = ~clk;

  bus_ctl_seq i_bus_ctl_seq (
    .clk(clk), .rst(rst), .opcode(opcode), .n_flag(n_flag),
    .drv_pc(drv_pc), .drv_alu(drv_alu), .drv_reg(drv_reg), .drv_mem(drv_mem),
    .drv_off(drv_off), .ld_pc(ld_pc), .ld_a(ld_a), .ld_b(ld_b), .ld_mar(ld_mar),
    .ld_ir(ld_ir), .ld_n(ld_n), .ld_z(ld_z), .wr_reg(wr_reg), .wr_mem(wr_mem),
    .reg_sel(reg_sel), .alu_fn(alu_fn)
  );

  function automatic logic [17:0] vec(logic [13:0] m, logic [1:0] sel, logic [1:0] fn);
    return {m, sel, fn};
  endfunction

  task automatic push(logic [17:0] v, string tag);
    if (budget > 0) begin
      q_vec.push_back(v);
      q_tag.push_back(tag);
      budget--;
      pushed++;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
  endtask

  // monitor: compare each cycle's outputs against the scoreboard front
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q_vec.size() > 0) begin
        logic [17:0] act;
        logic [17:0] exp_v;
        string       tag;
        act = {drv_pc, drv_alu, drv_reg, drv_mem, drv_off, ld_pc, ld_a, ld_b,
               ld_mar, ld_ir, ld_n, ld_z, wr_reg, wr_mem, reg_sel, alu_fn};
        exp_v = q_vec.pop_front();
        tag   = q_tag.pop_front();
        runs++;
        if (act !== exp_v) begin
          fails++;
          $display("FAIL %s: controls actual %b expected %b", tag, act, exp_v);
        end
        runs++;
        if ($countones(act[17:13]) > 1) begin
          fails++;
          $display("FAIL R10: drivers actual %b expected at most one", act[17:13]);
        end
      end
    end
  end

  // driver: one instruction, optionally cut short after 'limit' cycles
  task automatic run_instr(logic [3:0] op, logic nval, int limit);
    opcode = op;
    n_flag = nval;
    budget = (limit > 0) ? limit : 100;
    pushed = 0;
    push(vec(B_DPC | B_LA | B_LMAR, 2'b00, 2'b00), "R2");
    push(vec(B_DMEM | B_LIR, 2'b00, 2'b00), "R2");
    push(vec(B_DALU | B_LPC, 2'b00, 2'b11), "R2");
    if (op == 4'h4 || op == 4'h5) begin
      push(vec(B_DREG | B_LA, 2'b00, 2'b00), "R3");
      push(vec(B_DOFF | B_LB, 2'b00, 2'b00), "R4");
      push(vec(B_DALU | B_LMAR, 2'b00, 2'b00), "R4");
      if (op == 4'h4) push(vec(B_DMEM | B_WREG, 2'b01, 2'b00), "R5");
      else            push(vec(B_DREG | B_WMEM, 2'b01, 2'b00), "R6");
    end else if (op == 4'h9) begin
      push(vec(B_DREG | B_LA, 2'b00, 2'b00), "R3");
      push(vec(B_DREG | B_LB, 2'b01, 2'b00), "R7");
      push(vec(B_LN, 2'b00, 2'b10), "R7");
      push(vec(B_DREG | B_LA | B_LB, 2'b11, 2'b00), "R8");
      if (nval) push(vec(B_DALU | B_WREG, 2'b10, 2'b11), "R9");
      else      push(vec(B_DALU | B_WREG, 2'b10, 2'b00), "R9");
    end
    repeat (pushed) @(negedge clk);
  endtask

  task automatic reset_pulse();
    rst = 1'b1;
    budget = 1;
    pushed = 0;
    push(vec(14'h0, 2'b00, 2'b00), "R1");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    reset_pulse();                // R1: zeros while held, then fetch step 1
    run_instr(4'h0, 1'b0, 0);     // R3: unlisted opcode returns to fetch
    run_instr(4'h4, 1'b0, 0);     // R4 R5: load
    run_instr(4'h5, 1'b1, 0);     // R4 R6: store
    run_instr(4'h9, 1'b1, 0);     // R8 R9: result one
    run_instr(4'h9, 1'b0, 0);     // R8 R9: result zero
    run_instr(4'hF, 1'b1, 0);     // R3: another unlisted opcode
    run_instr(4'h4, 1'b0, 5);     // cut load after address step 2
    reset_pulse();                // R1: mid-instruction reset
    run_instr(4'h9, 1'b1, 6);     // cut compare before its result state
    reset_pulse();                // R1
    run_instr(4'h5, 1'b0, 0);     // R6 after reset
    run_instr(4'h9, 1'b0, 0);     // R9
    @(negedge clk);
    #2;
    runs++;
    if (q_vec.size() != 0) begin
      fails++;
      $display("FAIL R2: scoreboard left %0d expected 0", q_vec.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      runs++;
      fails++;
      $display("FAIL R1: watchdog expired actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule